// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps the outcome of finished transmissions in a small last-in, first-out stack. The host reads it one byte at a time. When a transmission ends, the transmit engine pushes one entry. The entry holds a completion mark, a flag saying the sender asked to be told of success, and three error flags: jabber, underrun and maximum collisions. The host reads the byte on `txc_status_o` to see the most recent entry. Any host write strobe to that register pops the entry. Nothing is stored by that write.

If a push arrives while the stack is full, the new entry is dropped. The entry the host sees next then carries an overflow mark. A push that asks for an interrupt, or that reports any error, raises a one-cycle transmit-done event.

Jabber and underrun results latch a halt condition. So does a transmit FIFO overrun input, which also raises a one-cycle adapter-failure event. The halt condition is cleared only by a transmit reset or by global reset. A transmit reset also empties the stack.

Top module: `txc_stack`

## Requirements
- R1: After global reset, `txc_status_o` is 0x00 and `halt_o`, `txdone_evt_o` and `fail_evt_o` are all low.
- R2: An accepted push is visible on `txc_status_o` from the cycle after the push. The byte layout is: bit 7 = 1 (complete), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow, and bits 1..0 = 0.
- R3: While the stack is empty, `txc_status_o` reads 0x00, so bit 7 is clear.
- R4: A `pop_i` strobe removes the top entry, and the next older entry is shown on the following cycle (last in, first out). A pop on an empty stack has no effect.
- R5: When DEPTH entries are held, a push is dropped. Bit 2 of the entry currently on top is set, and the older entries are unchanged.
- R6: When a push and a pop occur in the same cycle on a non-empty stack, the top entry is replaced by the new one, and the depth is unchanged.
- R7: `txdone_evt_o` is a one-cycle pulse in the cycle after a push whose interrupt, jabber, underrun or maximum-collision flag is set. A push with none of these flags gives no pulse.
- R8: A push with the jabber or underrun flag sets `halt_o` from the next cycle. `halt_o` then stays high through pops and further pushes until a transmit reset.
- R9: Assertion of `fifo_overrun_i` sets `halt_o` and gives exactly one `fail_evt_o` pulse, in the next cycle, however long the input stays high.
- R10: `txreset_i` empties the stack and clears `halt_o` from the next cycle. It takes priority over a push or a pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low |
| push_i | input | 1 | Transmit engine pushes a completion entry |
| push_irq_i | input | 1 | Entry flag: interrupt on success requested |
| push_jabber_i | input | 1 | Entry flag: jabber error |
| push_underrun_i | input | 1 | Entry flag: underrun |
| push_maxcoll_i | input | 1 | Entry flag: maximum collisions reached |
| pop_i | input | 1 | Host write strobe to the status register; pops the top entry |
| fifo_overrun_i | input | 1 | Transmit FIFO overrun condition |
| txreset_i | input | 1 | Transmit reset command |
| txc_status_o | output | 8 | Top entry, or 0x00 when the stack is empty |
| txdone_evt_o | output | 1 | Transmit-done event pulse |
| fail_evt_o | output | 1 | Adapter-failure event pulse |
| halt_o | output | 1 | Transmitter halted until transmit reset |

## Verification
A wrong depth count shows up at the port in one of two ways. The bench may see a non-zero byte where an empty stack should read zero. It may also see the wrong older entry after a pop. Each is visible in the cycle after the faulty pop or push.

A lost overflow mark, or an overflow mark on the wrong slot, appears at the first read after a push to a full stack. A bad halt latch shows on `halt_o` one cycle after the event that sets it or the reset that clears it. Event pulses are checked both in the cycle they must appear and in the cycle after, which catches pulses held too long.

// File: rtl/txc_pkg.sv
package txc_pkg;
    localparam int ENTRY_W   = 8;
    localparam int B_DONE    = 7;
    localparam int B_IRQ     = 6;
    localparam int B_JABBER  = 5;
    localparam int B_UNDER   = 4;
    localparam int B_MAXCOLL = 3;
    localparam int B_OVF     = 2;

    typedef struct packed {
        logic irq;
        logic jabber;
        logic underrun;
        logic maxcoll;
    } txc_flags_t;

    function automatic logic [ENTRY_W-1:0] make_entry(txc_flags_t f);
        logic [ENTRY_W-1:0] e;
        e            = '0;
        e[B_DONE]    = 1'b1;
        e[B_IRQ]     = f.irq;
        e[B_JABBER]  = f.jabber;
        e[B_UNDER]   = f.underrun;
        e[B_MAXCOLL] = f.maxcoll;
        return e;
    endfunction

    function automatic logic wants_event(txc_flags_t f);
        return f.irq | f.jabber | f.underrun | f.maxcoll;
    endfunction
endpackage

// File: rtl/txc_store.sv
module txc_store
    import txc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               push,
    input  logic               pop,
    input  logic [ENTRY_W-1:0] entry,
    output logic [ENTRY_W-1:0] top
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ENTRY_W-1:0] slot;
        logic [CW-1:0]                 cnt;
    } st_t;

    st_t  st_d, st_q;
    logic full;

    always_comb begin
        st_d = st_q;
        top  = '0;
        full = (st_q.cnt == CW'(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.cnt == CW'(i + 1)) top = st_q.slot[i];
        end
        if (clr) begin
            st_d = '0;
        end else if (push && pop && st_q.cnt != '0) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q.cnt == CW'(i + 1)) st_d.slot[i] = entry;
            end
        end else if (push) begin
            if (full) begin
                st_d.slot[DEPTH-1][B_OVF] = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (st_q.cnt == CW'(i)) st_d.slot[i] = entry;
                end
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else if (pop && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/txc_fault.sv
module txc_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_jabber,
    input  logic set_underrun,
    input  logic overrun,
    output logic halt,
    output logic fail_evt
);
    typedef struct packed {
        logic jabber;
        logic underrun;
        logic overrun;
        logic fail;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.fail = 1'b0;
        if (clr) begin
            flt_d = '0;
        end else begin
            if (set_jabber)   flt_d.jabber   = 1'b1;
            if (set_underrun) flt_d.underrun = 1'b1;
            if (overrun) begin
                flt_d.overrun = 1'b1;
                flt_d.fail    = ~flt_q.overrun;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign halt     = flt_q.jabber | flt_q.underrun | flt_q.overrun;
    assign fail_evt = flt_q.fail;
endmodule

// File: rtl/txc_event.sv
module txc_event
    import txc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  txc_flags_t flags,
    output logic       evt
);
    logic evt_d, evt_q;

    always_comb begin
        evt_d = push & wants_event(flags) & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= evt_d;
    end

    assign evt = evt_q;
endmodule

// File: rtl/txc_stack.sv
module txc_stack
    import txc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic       push_irq_i,
    input  logic       push_jabber_i,
    input  logic       push_underrun_i,
    input  logic       push_maxcoll_i,
    input  logic       pop_i,
    input  logic       fifo_overrun_i,
    input  logic       txreset_i,
    output logic [7:0] txc_status_o,
    output logic       txdone_evt_o,
    output logic       fail_evt_o,
    output logic       halt_o
);
    txc_flags_t         flags;
    logic [ENTRY_W-1:0] entry;

    always_comb begin
        flags.irq      = push_irq_i;
        flags.jabber   = push_jabber_i;
        flags.underrun = push_underrun_i;
        flags.maxcoll  = push_maxcoll_i;
        entry          = make_entry(flags);
    end

    txc_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (txreset_i),
        .push  (push_i),
        .pop   (pop_i),
        .entry (entry),
        .top   (txc_status_o)
    );

    txc_fault u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (txreset_i),
        .set_jabber   (push_i & push_jabber_i),
        .set_underrun (push_i & push_underrun_i),
        .overrun      (fifo_overrun_i),
        .halt         (halt_o),
        .fail_evt     (fail_evt_o)
    );

    txc_event u_event (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (txreset_i),
        .push  (push_i),
        .flags (flags),
        .evt   (txdone_evt_o)
    );
endmodule

// File: rtl/txc_stack_chk.sv
module txc_stack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       push_i,
    input logic       push_irq_i,
    input logic       push_jabber_i,
    input logic       push_underrun_i,
    input logic       push_maxcoll_i,
    input logic       pop_i,
    input logic       fifo_overrun_i,
    input logic       txreset_i,
    input logic [7:0] txc_status_o,
    input logic       txdone_evt_o,
    input logic       fail_evt_o,
    input logic       halt_o
);
    // R2: the low two bits of the status byte are always zero
    p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        txc_status_o[1:0] == 2'b00);

    // R2: after an accepted push the top entry is marked complete
    p_push_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && !txreset_i |=> txc_status_o[7]);

    // R7: a push asking for an interrupt raises the transmit-done event
    p_irq_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && push_irq_i && !txreset_i |=> txdone_evt_o);

    // R7: the transmit-done event occurs only after a push
    p_event_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        txdone_evt_o |-> $past(push_i));

    // R8: the halt condition holds until a transmit reset
    p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o && !txreset_i |=> halt_o);

    // R9: an adapter-failure event comes with the transmitter halted
    p_fail_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_evt_o |-> halt_o);

    // R10: a transmit reset empties the stack and clears the halt condition
    p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        txreset_i |=> txc_status_o == 8'h00 && !halt_o);
endmodule

bind txc_stack txc_stack_chk u_chk (.*);

// File: tb/txc_stack_bench.sv
module txc_stack_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0, push_irq_i = 1'b0, push_jabber_i = 1'b0;
    logic       push_underrun_i = 1'b0, push_maxcoll_i = 1'b0;
    logic       pop_i = 1'b0, fifo_overrun_i = 1'b0, txreset_i = 1'b0;
    logic [7:0] txc_status_o;
    logic       txdone_evt_o, fail_evt_o, halt_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    txc_stack u_txc_stack (.*);

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // push with flags {irq, jabber, underrun, maxcoll}; returns at the negedge after the edge
    task automatic do_push(logic [3:0] f, logic with_pop);
        @(negedge clk);
        {push_irq_i, push_jabber_i, push_underrun_i, push_maxcoll_i} = f;
        push_i = 1'b1;
        pop_i  = with_pop;
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
        {push_irq_i, push_jabber_i, push_underrun_i, push_maxcoll_i} = 4'b0;
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop_i = 1'b1;
        @(negedge clk);
        pop_i = 1'b0;
    endtask

    task automatic do_txreset();
        @(negedge clk);
        txreset_i = 1'b1;
        @(negedge clk);
        txreset_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", txc_status_o, 8'h00);
        check("R1 halt", {7'b0, halt_o}, 8'h00);
        check("R1 evt", {6'b0, txdone_evt_o, fail_evt_o}, 8'h00);
        check("R3 empty", txc_status_o, 8'h00);
    endtask

    task automatic t_encoding();
        do_push(4'b1000, 1'b0);
        check("R2 irq entry", txc_status_o, 8'hC0);
        check("R7 irq event", {7'b0, txdone_evt_o}, 8'h01);
        @(negedge clk);
        check("R7 one cycle", {7'b0, txdone_evt_o}, 8'h00);
        do_pop();
        check("R3 empty after pop", txc_status_o, 8'h00);
        do_push(4'b0001, 1'b0);
        check("R2 maxcoll entry", txc_status_o, 8'h88);
        check("R7 maxcoll event", {7'b0, txdone_evt_o}, 8'h01);
        do_pop();
        do_push(4'b0000, 1'b0);
        check("R2 plain entry", txc_status_o, 8'h80);
        check("R7 no event", {7'b0, txdone_evt_o}, 8'h00);
        do_pop();
    endtask

    task automatic t_lifo();
        do_push(4'b0000, 1'b0);
        do_push(4'b1000, 1'b0);
        do_push(4'b0001, 1'b0);
        check("R4 top", txc_status_o, 8'h88);
        do_pop();
        check("R4 second", txc_status_o, 8'hC0);
        do_pop();
        check("R4 third", txc_status_o, 8'h80);
        do_pop();
        check("R4 emptied", txc_status_o, 8'h00);
        do_pop();
        check("R4 pop on empty", txc_status_o, 8'h00);
        do_push(4'b1000, 1'b0);
        check("R4 after empty pop", txc_status_o, 8'hC0);
        do_pop();
        check("R4 single left", txc_status_o, 8'h00);
    endtask

    task automatic t_full();
        do_push(4'b0000, 1'b0);
        do_push(4'b1000, 1'b0);
        do_push(4'b0001, 1'b0);
        do_push(4'b0000, 1'b0);
        check("R5 full top", txc_status_o, 8'h80);
        do_push(4'b1000, 1'b0);
        check("R5 overflow mark", txc_status_o, 8'h84);
        do_pop();
        check("R5 kept 3", txc_status_o, 8'h88);
        do_pop();
        check("R5 kept 2", txc_status_o, 8'hC0);
        do_pop();
        check("R5 kept 1", txc_status_o, 8'h80);
        do_pop();
        check("R5 empty", txc_status_o, 8'h00);
    endtask

    task automatic t_swap();
        do_push(4'b0000, 1'b0);
        do_push(4'b1000, 1'b1);
        check("R6 replaced", txc_status_o, 8'hC0);
        do_pop();
        check("R6 depth kept", txc_status_o, 8'h00);
    endtask

    task automatic t_halt();
        do_push(4'b0100, 1'b0);
        check("R2 jabber entry", txc_status_o, 8'hA0);
        check("R8 jabber halt", {7'b0, halt_o}, 8'h01);
        check("R7 jabber event", {7'b0, txdone_evt_o}, 8'h01);
        do_pop();
        repeat (5) @(negedge clk);
        check("R8 halt held", {7'b0, halt_o}, 8'h01);
        do_push(4'b0000, 1'b0);
        check("R8 halt after push", {7'b0, halt_o}, 8'h01);
        do_txreset();
        check("R10 halt cleared", {7'b0, halt_o}, 8'h00);
        check("R10 stack emptied", txc_status_o, 8'h00);
        do_push(4'b0010, 1'b0);
        check("R2 underrun entry", txc_status_o, 8'h90);
        check("R8 underrun halt", {7'b0, halt_o}, 8'h01);
        do_txreset();
        check("R10 underrun cleared", {7'b0, halt_o}, 8'h00);
    endtask

    task automatic t_overrun();
        int pulses = 0;
        @(negedge clk);
        fifo_overrun_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (fail_evt_o) pulses++;
            if (i == 0) check("R9 fail first cycle", {7'b0, fail_evt_o}, 8'h01);
        end
        fifo_overrun_i = 1'b0;
        @(negedge clk);
        if (fail_evt_o) pulses++;
        check("R9 single pulse", 8'(pulses), 8'h01);
        check("R9 halt", {7'b0, halt_o}, 8'h01);
        do_txreset();
        check("R10 overrun cleared", {7'b0, halt_o}, 8'h00);
    endtask

    task automatic t_reset_priority();
        do_push(4'b0000, 1'b0);
        do_push(4'b0000, 1'b0);
        @(negedge clk);
        txreset_i = 1'b1;
        push_i = 1'b1;
        push_irq_i = 1'b1;
        @(negedge clk);
        txreset_i = 1'b0;
        push_i = 1'b0;
        push_irq_i = 1'b0;
        check("R10 reset beats push", txc_status_o, 8'h00);
        check("R10 no event", {7'b0, txdone_evt_o}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_encoding();
        t_lifo();
        t_full();
        t_swap();
        t_halt();
        t_overrun();
        t_reset_priority();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule